// File: doc/BRIEF.md
# Dual GPIO Port Controller

This block gives a processor bus byte-wide access to two 8-bit pin ports. The first is a plain general-purpose port. The second is a special-function port whose top register bits are taken over for control duties. Each port has three addresses: a configuration register, an output data register, and a read-only view of the pin levels. For each pin, the configuration bit and the data bit together select one of four pad behaviours. Those behaviours reach the pad ring as output-enable, output-value and pull-up-enable vectors.

On the special port, the two upper data bits do not store anything. A 1 written to either bit fires a one-cycle low-power request: bit 7 requests halt and bit 6 requests idle. The two upper configuration bits are stored and brought out as control levels: bit 6 selects the alternate serial clock phase, and bit 7 enables a clock start-up delay after halt. The block can never drive or pull up special pins 1, 6 and 7. While halted in RC-oscillator mode, a synchronized rising edge on special pin 7 ends the halt.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all configuration and data registers read 0. All oe, out and pu outputs are 0, and halt_req, idle_req, halted, wake_pulse, sk_alt_phase and start_delay_en are 0.
- R2: Address map, with read data combinational from bus_addr. 0 is the general configuration register, 1 the general data register and 2 the general pin view. 4 is the special configuration register, 5 the special data register and 6 the special pin view. Reads at 3 and 7 return 0. Writes to 2, 3, 6 and 7 change nothing. A write lands on the clock edge where bus_wr is 1.
- R3: For every general pin, and every special pin other than 1, 6 and 7, the output after a write depends on configuration bit c and data bit d. With c=0 and d=0 the pin is high-impedance: oe=0 and pu=0. With c=0 and d=1 it is an input with pull-up: oe=0 and pu=1. With c=1 it drives push-pull: oe=1, out=d and pu=0. When oe=0, out is 0. The new values show in the cycle after the write edge.
- R4: A pin view reads the pad inputs through two flip-flops. A pad change first shows after the second rising clock edge that follows it, and not after the first.
- R5: A write to address 5 with bit 7 set raises halt_req for exactly one cycle after the write edge. Bit 6 does the same for idle_req. Special data bits 7 and 6 always read 0, and bits 5..0 read back what was written.
- R6: Special configuration bit 6 drives sk_alt_phase and bit 7 drives start_delay_en. Both read back at address 4.
- R7: Special pins 1, 6 and 7 always have oe=0, out=0 and pu=0, whatever the register contents.
- R8: halted sets on the same edge as a halt request. It stays set until a wake, or until reset.
- R9: When rc_osc_mode=1 and halted=1, a rising edge on special pad 7 gives wake_pulse=1 for one cycle. This happens once the edge has passed through the two synchronizer stages. halted clears on the next edge. With rc_osc_mode=0 or halted=0 the edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rc_osc_mode | input | 1 | RC oscillator option: pin 7 is an input and a wake source |
| gp_pad_in | input | 8 | General port pad levels |
| gp_oe | output | 8 | General port output enables |
| gp_out | output | 8 | General port output values |
| gp_pu | output | 8 | General port pull-up enables |
| sp_pad_in | input | 8 | Special port pad levels |
| sp_oe | output | 8 | Special port output enables |
| sp_out | output | 8 | Special port output values |
| sp_pu | output | 8 | Special port pull-up enables |
| halt_req | output | 1 | One-cycle halt request |
| idle_req | output | 1 | One-cycle idle request |
| halted | output | 1 | Halt state flag |
| wake_pulse | output | 1 | One-cycle wake from halt |
| sk_alt_phase | output | 1 | Alternate serial clock phase select |
| start_delay_en | output | 1 | Clock start-up delay enable after halt |

## Verification
The hardest case to reach is the wake from halt. It needs three things at once: the halted state set by a halt write, the RC option on, and a rising edge on pin 7 that has passed through both synchronizer stages. The wake pulse lasts only one cycle. The stimulus issues the halt write first, then raises pad 7 on a falling edge. It then samples after one, two and three rising edges: no pulse yet, then the pulse with halted still set, then halted cleared. The same sequence is repeated with the RC option off, and again without a halt, to show the edge is ignored.

// File: rtl/gpio_pair_pkg.sv
// Package: shared constants and types for the dual GPIO port controller.
// Assumes byte-wide ports and a 3-bit register address space.
package gpio_pair_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    // Register addresses (general port at 0..2, special port at 4..6)
    localparam logic [ADDR_W-1:0] A_GP_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] A_GP_DAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_GP_PIN = 3'd2;
    localparam logic [ADDR_W-1:0] A_SP_CFG = 3'd4;
    localparam logic [ADDR_W-1:0] A_SP_DAT = 3'd5;
    localparam logic [ADDR_W-1:0] A_SP_PIN = 3'd6;

    // Special port control bit positions
    localparam int HALT_BIT  = 7;
    localparam int IDLE_BIT  = 6;
    localparam int DLY_BIT   = 7;
    localparam int PHASE_BIT = 6;
    localparam int WDOG_PIN  = 1;
    localparam int WAKE_PIN  = 7;
    // Number of stored special data bits (below the strobe bits)
    localparam int SP_DAT_W  = IDLE_BIT;

    // Pins of the special port this block may never drive or pull
    localparam logic [PORT_W-1:0] SP_LOCK =
        (PORT_W'(1) << WDOG_PIN) | (PORT_W'(1) << IDLE_BIT) | (PORT_W'(1) << HALT_BIT);

    // Per-pin pad control bundle
    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-stage synchronizer for a vector of pad inputs.
// Assumes each bit is independent; no bus coherence across bits.
module gpio_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift pad levels through two flops, clearing on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pad_drive.sv
// Turns configuration/data bit pairs into pad enables and values.
// LOCK marks pins that must stay undriven and unpulled.
module gpio_pad_drive
    import gpio_pair_pkg::*;
#(
    parameter int          W    = 8,
    parameter logic [W-1:0] LOCK = '0
) (
    input  logic [W-1:0] cfg,
    input  logic [W-1:0] dat,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    pad_ctl_t ctl [W];

    for (genvar i = 0; i < W; i++) begin : g_pin
        // Decode one pin's mode, then blank it if locked
        always_comb begin
            ctl[i].oe  = cfg[i];
            ctl[i].out = cfg[i] & dat[i];
            ctl[i].pu  = ~cfg[i] & dat[i];
            if (LOCK[i]) begin
                ctl[i] = '0;
            end
        end
        assign oe[i]  = ctl[i].oe;
        assign out[i] = ctl[i].out;
        assign pu[i]  = ctl[i].pu;
    end
endmodule

// File: rtl/gpio_power_ctl.sv
// Low-power request strobes, halt state and pin-driven wake detection.
// Assumes wake_sync is already synchronized to clk.
module gpio_power_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic dat_wr,
    input  logic halt_bit,
    input  logic idle_bit,
    input  logic rc_mode,
    input  logic wake_sync,
    output logic halt_req,
    output logic idle_req,
    output logic halted,
    output logic wake_pulse
);
    logic wake_prev;

    // Rising edge on the synchronized wake pin while halted in RC mode
    assign wake_pulse = rc_mode & halted & wake_sync & ~wake_prev;

    // Self-clearing request strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_req <= 1'b0;
            idle_req <= 1'b0;
        end else begin
            halt_req <= dat_wr & halt_bit;
            idle_req <= dat_wr & idle_bit;
        end
    end

    // Halt state: set by a halt request, cleared by a wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (dat_wr && halt_bit) begin
            halted <= 1'b1;
        end else if (wake_pulse) begin
            halted <= 1'b0;
        end
    end

    // Remember the last synchronized wake pin level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_prev <= 1'b0;
        end else begin
            wake_prev <= wake_sync;
        end
    end
endmodule

// File: rtl/gpio_pair_ctrl.sv
// Top: register file and read mux for one general and one special port.
// Assumes a single-cycle write strobe and a combinational read.
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              rc_osc_mode,
    input  logic [PORT_W-1:0] gp_pad_in,
    output logic [PORT_W-1:0] gp_oe,
    output logic [PORT_W-1:0] gp_out,
    output logic [PORT_W-1:0] gp_pu,
    input  logic [PORT_W-1:0] sp_pad_in,
    output logic [PORT_W-1:0] sp_oe,
    output logic [PORT_W-1:0] sp_out,
    output logic [PORT_W-1:0] sp_pu,
    output logic              halt_req,
    output logic              idle_req,
    output logic              halted,
    output logic              wake_pulse,
    output logic              sk_alt_phase,
    output logic              start_delay_en
);
    localparam int PAD_W = PORT_W - SP_DAT_W;

    logic [PORT_W-1:0]   gp_cfg, gp_dat, sp_cfg;
    logic [SP_DAT_W-1:0] sp_dat;
    logic [PORT_W-1:0]   gp_sync, sp_sync;
    logic                sp_dat_wr;

    assign sp_dat_wr = bus_wr && (bus_addr == A_SP_DAT);

    // Register writes for both ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_cfg <= '0;
            gp_dat <= '0;
            sp_cfg <= '0;
            sp_dat <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_GP_CFG: gp_cfg <= bus_wdata;
                A_GP_DAT: gp_dat <= bus_wdata;
                A_SP_CFG: sp_cfg <= bus_wdata;
                A_SP_DAT: sp_dat <= bus_wdata[SP_DAT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Read mux; strobe bits of the special data register read as zero
    always_comb begin
        case (bus_addr)
            A_GP_CFG: bus_rdata = gp_cfg;
            A_GP_DAT: bus_rdata = gp_dat;
            A_GP_PIN: bus_rdata = gp_sync;
            A_SP_CFG: bus_rdata = sp_cfg;
            A_SP_DAT: bus_rdata = {{PAD_W{1'b0}}, sp_dat};
            A_SP_PIN: bus_rdata = sp_sync;
            default:  bus_rdata = '0;
        endcase
    end

    assign sk_alt_phase   = sp_cfg[PHASE_BIT];
    assign start_delay_en = sp_cfg[DLY_BIT];

    gpio_pin_sync #(.W(PORT_W)) u_gp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gp_pad_in),
        .q     (gp_sync)
    );

    gpio_pin_sync #(.W(PORT_W)) u_sp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sp_pad_in),
        .q     (sp_sync)
    );

    gpio_pad_drive #(.W(PORT_W), .LOCK('0)) u_gp_drive (
        .cfg (gp_cfg),
        .dat (gp_dat),
        .oe  (gp_oe),
        .out (gp_out),
        .pu  (gp_pu)
    );

    gpio_pad_drive #(.W(PORT_W), .LOCK(SP_LOCK)) u_sp_drive (
        .cfg (sp_cfg),
        .dat ({{PAD_W{1'b0}}, sp_dat}),
        .oe  (sp_oe),
        .out (sp_out),
        .pu  (sp_pu)
    );

    gpio_power_ctl u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat_wr     (sp_dat_wr),
        .halt_bit   (bus_wdata[HALT_BIT]),
        .idle_bit   (bus_wdata[IDLE_BIT]),
        .rc_mode    (rc_osc_mode),
        .wake_sync  (sp_sync[WAKE_PIN]),
        .halt_req   (halt_req),
        .idle_req   (idle_req),
        .halted     (halted),
        .wake_pulse (wake_pulse)
    );
endmodule

// File: rtl/gpio_pair_ctrl_chk.sv
// Checker: temporal properties on the top module's ports, bound in below.
module gpio_pair_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       rc_osc_mode,
    input logic [7:0] gp_oe,
    input logic [7:0] gp_pu,
    input logic [7:0] sp_oe,
    input logic [7:0] sp_out,
    input logic [7:0] sp_pu,
    input logic       halt_req,
    input logic       idle_req,
    input logic       halted,
    input logic       wake_pulse,
    input logic       sk_alt_phase
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gp_oe == 8'h0 && gp_pu == 8'h0 && sp_oe == 8'h0 && !halted && !halt_req));

    assert_cfg_to_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> (gp_oe == $past(bus_wdata)));

    assert_halt_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(bus_wr && bus_addr == 3'd5 && bus_wdata[7]));

    assert_idle_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> $past(bus_wr && bus_addr == 3'd5 && bus_wdata[6]));

    assert_strobe_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd5) |-> (bus_rdata[7:6] == 2'b00));

    assert_phase_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> (sk_alt_phase == $past(bus_wdata[6])));

    assert_locked_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sp_oe & 8'hC2) == 8'h0) && ((sp_pu & 8'hC2) == 8'h0) && ((sp_out & 8'hC2) == 8'h0));

    assert_halt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> halted);

    assert_wake_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (halted && rc_osc_mode));

    assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && !(bus_wr && bus_addr == 3'd5 && bus_wdata[7])) |=> !halted);
endmodule

bind gpio_pair_ctrl gpio_pair_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .rc_osc_mode (rc_osc_mode),
    .gp_oe       (gp_oe),
    .gp_pu       (gp_pu),
    .sp_oe       (sp_oe),
    .sp_out      (sp_out),
    .sp_pu       (sp_pu),
    .halt_req    (halt_req),
    .idle_req    (idle_req),
    .halted      (halted),
    .wake_pulse  (wake_pulse),
    .sk_alt_phase(sk_alt_phase)
);

// File: tb/sim_gpio_pair_ctrl.sv
module sim_gpio_pair_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rc_osc_mode = 1'b0;
    logic [7:0] gp_pad_in = '0;
    logic [7:0] gp_oe, gp_out, gp_pu;
    logic [7:0] sp_pad_in = '0;
    logic [7:0] sp_oe, sp_out, sp_pu;
    logic       halt_req, idle_req, halted, wake_pulse, sk_alt_phase, start_delay_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_pair_ctrl u0 (.*);

    // {cfg, data, expected oe, expected out, expected pu}
    localparam logic [39:0] VEC [6] = '{
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},
        {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00},
        {8'hF0, 8'hCC, 8'hF0, 8'hC0, 8'h0C},
        {8'h5A, 8'h3C, 8'h5A, 8'h18, 8'h24}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({gp_oe, gp_out, gp_pu, sp_oe, sp_out, sp_pu} == '0, "R1 pads", gp_oe, 0);
        chk({halt_req, idle_req, halted, wake_pulse, sk_alt_phase, start_delay_en} == '0, "R1 ctl", halted, 0);
        rd_chk(3'd0, 8'h00, "R1 gcfg");
        rd_chk(3'd5, 8'h00, "R1 sdat");

        // R3: mode table on the general port
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, VEC[i][39:32]);
            wr(3'd1, VEC[i][31:24]);
            chk(gp_oe == VEC[i][23:16], "R3 oe", gp_oe, VEC[i][23:16]);
            chk(gp_out == VEC[i][15:8], "R3 out", gp_out, VEC[i][15:8]);
            chk(gp_pu == VEC[i][7:0], "R3 pu", gp_pu, VEC[i][7:0]);
            rd_chk(3'd0, VEC[i][39:32], "R2 gcfg readback");
            rd_chk(3'd1, VEC[i][31:24], "R2 gdat readback");
        end

        // R2: writes to read-only/unused addresses change nothing
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd7, 8'hFF);
        rd_chk(3'd0, 8'h5A, "R2 gcfg untouched");
        rd_chk(3'd1, 8'h3C, "R2 gdat untouched");
        rd_chk(3'd3, 8'h00, "R2 hole reads zero");
        rd_chk(3'd7, 8'h00, "R2 hole reads zero");
        chk(sp_oe == 8'h00, "R2 special isolated", sp_oe, 0);

        // R4: two-flop delay on the pin views
        @(negedge clk); gp_pad_in = 8'hA5; sp_pad_in = 8'h3C;
        @(negedge clk);
        rd_chk(3'd2, 8'h00, "R4 one edge");
        @(negedge clk);
        rd_chk(3'd2, 8'hA5, "R4 two edges");
        rd_chk(3'd6, 8'h3C, "R4 special pins");
        sp_pad_in = 8'h00;
        repeat (3) @(negedge clk);

        // R7 and R3 on the special port
        wr(3'd5, 8'h3F);
        wr(3'd4, 8'h3F);
        chk(sp_oe == 8'h3D, "R7 oe lock", sp_oe, 8'h3D);
        chk(sp_out == 8'h3D, "R3 special out", sp_out, 8'h3D);
        wr(3'd4, 8'h00);
        chk(sp_pu == 8'h3D, "R7 pu lock", sp_pu, 8'h3D);
        chk(sp_oe == 8'h00, "R3 special hi-z", sp_oe, 0);

        // R6: control bits
        wr(3'd4, 8'h80);
        chk(start_delay_en && !sk_alt_phase, "R6 delay", {sk_alt_phase, start_delay_en}, 2'b01);
        wr(3'd4, 8'h40);
        chk(!start_delay_en && sk_alt_phase, "R6 phase", {sk_alt_phase, start_delay_en}, 2'b10);
        rd_chk(3'd4, 8'h40, "R6 readback");
        wr(3'd4, 8'h00);

        // R5: idle strobe is one cycle, bits not stored
        wr(3'd5, 8'h55);
        chk(idle_req && !halt_req, "R5 idle pulse", {halt_req, idle_req}, 2'b01);
        rd_chk(3'd5, 8'h15, "R5 strobe bits read zero");
        @(negedge clk);
        chk(!idle_req, "R5 idle clears", idle_req, 0);
        chk(!halted, "R8 idle not halt", halted, 0);

        // R5/R8: halt strobe and state
        wr(3'd5, 8'h80);
        chk(halt_req && halted, "R5 halt pulse", {halt_req, halted}, 2'b11);
        @(negedge clk);
        chk(!halt_req && halted, "R8 halted held", {halt_req, halted}, 2'b01);

        // R9: edge ignored without RC option
        rc_osc_mode = 1'b0; sp_pad_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        chk(halted && !wake_pulse, "R9 no rc no wake", halted, 1);
        sp_pad_in[7] = 1'b0;
        repeat (3) @(negedge clk);

        // R9: wake in RC mode
        rc_osc_mode = 1'b1; sp_pad_in[7] = 1'b1;
        @(negedge clk);
        chk(!wake_pulse, "R9 wake one edge", wake_pulse, 0);
        @(negedge clk);
        chk(wake_pulse && halted, "R9 wake pulse", {wake_pulse, halted}, 2'b11);
        @(negedge clk);
        chk(!wake_pulse && !halted, "R9 halt cleared", {wake_pulse, halted}, 2'b00);

        // R9: edge ignored when not halted
        sp_pad_in[7] = 1'b0;
        repeat (3) @(negedge clk);
        sp_pad_in[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!wake_pulse && !halted, "R9 not halted ignored", wake_pulse, 0);

        // R1: reset mid-run clears state
        wr(3'd5, 8'h80);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!halted && gp_oe == 8'h00, "R1 re-reset", {halted, gp_oe}, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule